// File: doc/BRIEF.md
# Display Identification Fetch Sequencer

This block reads a display's identification data through an abstract byte-level auxiliary-channel request port. It handles one request at a time. Each request is a single-byte I2C-over-AUX read, a native register read or a native register write. After a start pulse the sequencer first reads the extension count. It then fetches the base 128-byte block, and a second 128-byte block only when the count is nonzero. It checks that each block sums to zero modulo 256. If the sink is requesting the identification-read compliance test, the sequencer writes back the checksum byte of the last block it read and then sets the test-response flag.

All fetched bytes go into an internal 256-byte store. A registered read port gives access to them. The sequence ends with a one-cycle done pulse and a held status code. The status is success, checksum warning or transport error. A transport failure stops the sequence at once. A bad checksum also stops it, with a warning status.

Top module: `edid_fetch_seq`

## Requirements
- R1: After reset, busy, done and aux_req_valid are 0 and status is 0 (none).
- R2: The first request after an accepted start is kind 0 (I2C read) to device 7'h50 at address 20'h0007E.
- R3: The base block is read as 128 single-byte I2C reads to device 7'h50 at offsets 0x00 through 0x7F in ascending order. Each byte is stored at the same buffer index, and rd_data shows buffer[rd_addr] one cycle after rd_addr is presented.
- R4: When the extension count is nonzero, offsets 0x80 through 0xFF are read in ascending order and stored at indices 128 through 255. When the count is zero, no read at an offset of 0x80 or above is issued.
- R5: If the 8-bit wrapping sum of a block's 128 bytes is not zero, the sequence ends with status 2 (checksum) and issues no further request.
- R6: After the last good block, a kind 1 (register read) request goes to address 20'h00218. If bit 2 of the returned byte is clear, the sequence ends with status 1 (ok) and issues no write.
- R7: If that bit 2 is set, a kind 2 (register write) goes to 20'h00261 carrying the byte at offset 0x7F of the last block read. A kind 2 write of 8'h04 to 20'h00260 follows, and the sequence ends with status 1.
- R8: An acknowledge with aux_ok low ends the sequence in the next cycle with status 3 (transport error), and no further request is issued.
- R9: A start pulse while busy is ignored: the running sequence issues exactly the same requests and produces a single done pulse.
- R10: done is a single-cycle pulse during which busy is already low. busy is high from the cycle after an accepted start until done. status is cleared by an accepted start and otherwise held until the next one.
- R11: While aux_req_valid is high and aux_ack is low, the request fields hold stable. A request completes only in the cycle in which aux_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 none, 1 ok, 2 checksum warning, 3 transport error |
| aux_req_valid | output | 1 | Request outstanding |
| aux_req_kind | output | 2 | 0 I2C read, 1 register read, 2 register write |
| aux_req_dev | output | 7 | I2C device address for kind 0 |
| aux_req_addr | output | 20 | Byte offset (I2C) or register address |
| aux_req_wdata | output | 8 | Write byte for kind 2 |
| aux_ack | input | 1 | Request complete; valid only while aux_req_valid is high |
| aux_ok | input | 1 | Transaction succeeded, sampled with aux_ack |
| aux_rdata | input | 8 | Read byte, sampled with aux_ack |
| rd_addr | input | 8 | Buffer read index |
| rd_data | output | 8 | Buffer byte, one cycle after rd_addr |

The request side follows valid/ready rules, with aux_ack acting as ready. The responder may hold off for any number of cycles. The block keeps every request field unchanged until the acknowledge. It may present the next request in the cycle right after an acknowledge.

## Verification
A wrong byte counter shows up on the very next request, as a wrong or non-ascending I2C offset. A wrong block selector shows up in the same way, and also as buffer contents at the wrong index. A corrupt checksum accumulator stays hidden until the last byte of a block. It then shows as a wrong status, or as a spurious or missing register read, at most 128 transactions later. Errors in the final-state branching show in the next cycle at the request port: an unexpected write, a missing response write, or a request issued after a failure or a checksum warning.

// File: rtl/edid_pkg.sv
package edid_pkg;
  typedef enum logic [1:0] {
    REQ_I2C_RD  = 2'd0,
    REQ_REG_RD  = 2'd1,
    REQ_REG_WR  = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_NONE  = 2'd0,
    ST_OK    = 2'd1,
    ST_CSUM  = 2'd2,
    ST_IOERR = 2'd3
  } seq_status_e;

  typedef enum logic [2:0] {
    P_IDLE, P_EXTCNT, P_BLOCK, P_TESTREQ, P_TESTCS, P_TESTRSP
  } seq_phase_e;

  localparam logic [19:0] A_EXT_FLAG  = 20'h0007E;
  localparam logic [19:0] A_TEST_REQ  = 20'h00218;
  localparam logic [19:0] A_TEST_CSUM = 20'h00261;
  localparam logic [19:0] A_TEST_RSP  = 20'h00260;
  localparam logic [7:0]  TEST_RD_BIT_MASK = 8'h04;
  localparam logic [7:0]  CSUM_WRITTEN     = 8'h04;
endpackage

// File: rtl/edid_blk_acc.sv
module edid_blk_acc #(
  parameter int BLK_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [7:0]        din,
  output logic [BLK_AW-1:0] idx,
  output logic              last,
  output logic              sum_zero
);
  logic [7:0] acc;
  logic [7:0] acc_nxt;

  assign acc_nxt  = acc + din;
  assign sum_zero = (acc_nxt == 8'h00);
  assign last     = &idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      idx <= '0;
    end else if (clr) begin
      acc <= '0;
      idx <= '0;
    end else if (add) begin
      acc <= acc_nxt;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/edid_store.sv
module edid_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/edid_ctrl.sv
module edid_ctrl
  import edid_pkg::*;
#(
  parameter int BLK_AW = 7,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              ack,
  input  logic              ok,
  input  logic [7:0]        rdata,
  input  logic [BLK_AW-1:0] idx,
  input  logic              blk_last,
  input  logic              blk_sum_zero,
  output logic              acc_clr,
  output logic              acc_add,
  output logic              buf_we,
  output logic [BLK_AW:0]   buf_waddr
);
  localparam int PAD_W = ADDR_W - BLK_AW - 1;

  seq_phase_e phase;
  logic       blk_sel;
  logic       ext_nz;
  logic [7:0] last_cs;
  logic       take;
  logic       good;

  assign take      = ack && req_valid;
  assign good      = take && ok;
  assign req_valid = (phase != P_IDLE);
  assign busy      = req_valid;
  assign buf_waddr = {blk_sel, idx};
  assign buf_we    = good && (phase == P_BLOCK);
  assign acc_add   = buf_we;
  assign acc_clr   = (phase == P_IDLE && start) ||
                     (buf_we && blk_last && blk_sum_zero && ext_nz && !blk_sel);

  always_comb begin
    req_kind  = REQ_I2C_RD;
    req_addr  = '0;
    req_wdata = '0;
    unique case (phase)
      P_EXTCNT:  req_addr = A_EXT_FLAG;
      P_BLOCK:   req_addr = {{PAD_W{1'b0}}, blk_sel, idx};
      P_TESTREQ: begin req_kind = REQ_REG_RD; req_addr = A_TEST_REQ; end
      P_TESTCS:  begin req_kind = REQ_REG_WR; req_addr = A_TEST_CSUM; req_wdata = last_cs; end
      P_TESTRSP: begin req_kind = REQ_REG_WR; req_addr = A_TEST_RSP;  req_wdata = CSUM_WRITTEN; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      blk_sel <= 1'b0;
      ext_nz  <= 1'b0;
      last_cs <= '0;
      done    <= 1'b0;
      status  <= ST_NONE;
    end else begin
      done <= 1'b0;
      if (phase == P_IDLE) begin
        if (start) begin
          phase   <= P_EXTCNT;
          status  <= ST_NONE;
          blk_sel <= 1'b0;
        end
      end else if (take && !ok) begin
        phase  <= P_IDLE;
        done   <= 1'b1;
        status <= ST_IOERR;
      end else if (good) begin
        unique case (phase)
          P_EXTCNT: begin
            ext_nz <= (rdata != 8'h00);
            phase  <= P_BLOCK;
          end
          P_BLOCK: begin
            if (blk_last) begin
              last_cs <= rdata;
              if (!blk_sum_zero) begin
                phase  <= P_IDLE;
                done   <= 1'b1;
                status <= ST_CSUM;
              end else if (ext_nz && !blk_sel) begin
                blk_sel <= 1'b1;
              end else begin
                phase <= P_TESTREQ;
              end
            end
          end
          P_TESTREQ: begin
            if ((rdata & TEST_RD_BIT_MASK) != 8'h00) begin
              phase <= P_TESTCS;
            end else begin
              phase  <= P_IDLE;
              done   <= 1'b1;
              status <= ST_OK;
            end
          end
          P_TESTCS: phase <= P_TESTRSP;
          P_TESTRSP: begin
            phase  <= P_IDLE;
            done   <= 1'b1;
            status <= ST_OK;
          end
          default: phase <= P_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
  import edid_pkg::*;
#(
  parameter int          BLK_AW   = 7,
  parameter int          ADDR_W   = 20,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              aux_req_valid,
  output logic [1:0]        aux_req_kind,
  output logic [6:0]        aux_req_dev,
  output logic [ADDR_W-1:0] aux_req_addr,
  output logic [7:0]        aux_req_wdata,
  input  logic              aux_ack,
  input  logic              aux_ok,
  input  logic [7:0]        aux_rdata,
  input  logic [BLK_AW:0]   rd_addr,
  output logic [7:0]        rd_data
);
  logic [BLK_AW-1:0] idx;
  logic              blk_last, blk_sum_zero;
  logic              acc_clr, acc_add;
  logic              buf_we;
  logic [BLK_AW:0]   buf_waddr;

  assign aux_req_dev = DEV_ADDR;

  edid_ctrl #(.BLK_AW(BLK_AW), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .status(status),
    .req_valid(aux_req_valid), .req_kind(aux_req_kind),
    .req_addr(aux_req_addr), .req_wdata(aux_req_wdata),
    .ack(aux_ack), .ok(aux_ok), .rdata(aux_rdata),
    .idx(idx), .blk_last(blk_last), .blk_sum_zero(blk_sum_zero),
    .acc_clr(acc_clr), .acc_add(acc_add),
    .buf_we(buf_we), .buf_waddr(buf_waddr)
  );

  edid_blk_acc #(.BLK_AW(BLK_AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
    .din(aux_rdata), .idx(idx), .last(blk_last), .sum_zero(blk_sum_zero)
  );

  edid_store #(.AW(BLK_AW + 1)) u_store (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(aux_rdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic              aux_req_valid,
  input logic [1:0]        aux_req_kind,
  input logic [ADDR_W-1:0] aux_req_addr,
  input logic [7:0]        aux_req_wdata,
  input logic              aux_ack,
  input logic              aux_ok
);
  assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req_valid && !aux_ack |=> aux_req_valid && $stable(aux_req_kind) &&
    $stable(aux_req_addr) && $stable(aux_req_wdata));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && (status != 2'd0));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(status));

  assert_fail_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req_valid && aux_ack && !aux_ok |=> done && !aux_req_valid && status == 2'd3);

  assert_csum_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 2'd2 |-> !aux_req_valid);

  assert_write_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req_valid && aux_req_kind == 2'd2 |->
    (aux_req_addr == 20'h00261 || (aux_req_addr == 20'h00260 && aux_req_wdata == 8'h04)));
endmodule

bind edid_fetch_seq edid_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .aux_req_valid(aux_req_valid), .aux_req_kind(aux_req_kind),
  .aux_req_addr(aux_req_addr), .aux_req_wdata(aux_req_wdata),
  .aux_ack(aux_ack), .aux_ok(aux_ok)
);

// File: tb/sim_edid_fetch_seq.sv
`timescale 1ns/1ps
module sim_edid_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [1:0]  status;
  logic        aux_req_valid;
  logic [1:0]  aux_req_kind;
  logic [6:0]  aux_req_dev;
  logic [19:0] aux_req_addr;
  logic [7:0]  aux_req_wdata;
  logic        aux_ack = 1'b0;
  logic        aux_ok = 1'b0;
  logic [7:0]  aux_rdata = 8'h00;
  logic [7:0]  rd_addr = 8'h00;
  logic [7:0]  rd_data;

  always #10 clk = ~clk;

  edid_fetch_seq u0 (.*);

  int errors = 0, checks = 0;
  logic [7:0]  sink_mem [256];
  logic [7:0]  test_reg;
  int          fail_at = -1;
  int          lat = 0;
  int          ntx = 0;
  int          wait_cnt = 0;
  logic [1:0]  log_kind [400];
  logic [19:0] log_addr [400];
  logic [7:0]  log_data [400];
  logic [6:0]  log_dev  [400];
  int          done_cnt = 0;
  logic [1:0]  done_status;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder model
  initial forever begin
    @(negedge clk);
    if (aux_ack) begin
      aux_ack = 1'b0;
      wait_cnt = 0;
    end else if (aux_req_valid) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        log_kind[ntx] = aux_req_kind;
        log_addr[ntx] = aux_req_addr;
        log_data[ntx] = aux_req_wdata;
        log_dev[ntx]  = aux_req_dev;
        if (aux_req_kind == 2'd0) aux_rdata = sink_mem[aux_req_addr[7:0]];
        else if (aux_req_kind == 2'd1) aux_rdata = (aux_req_addr == 20'h00218) ? test_reg : 8'h00;
        else aux_rdata = 8'h00;
        aux_ok = (ntx != fail_at);
        if (ntx < 399) ntx++;
        aux_ack = 1'b1;
      end
    end
  end

  always @(negedge clk) if (done) begin
    done_cnt++;
    done_status = status;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  function automatic void build(input logic [7:0] ext, input bit bad0, input bit bad1, input int seed);
    for (int b = 0; b < 2; b++) begin
      logic [7:0] s;
      s = 8'h00;
      for (int i = 0; i < 127; i++) begin
        sink_mem[b*128+i] = 8'((i * 7 + seed * 13 + b * 31 + 3) & 255);
        if (b == 0 && i == 126) sink_mem[i] = ext;
        s = s + sink_mem[b*128+i];
      end
      sink_mem[b*128+127] = 8'h00 - s;
    end
    if (bad0) sink_mem[5]   = sink_mem[5] + 8'h01;
    if (bad1) sink_mem[133] = sink_mem[133] + 8'h01;
  endfunction

  task automatic run(input int extra_start_at);
    int d0;
    d0 = done_cnt;
    ntx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    for (int c = 0; c < 5000 && done_cnt == d0; c++) begin
      if (c == extra_start_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    chk(done_cnt == d0 + 1, "R10 one done", done_cnt - d0, 1);
    chk(done == 1'b0 && busy == 1'b0, "R10 done single cycle", done, 0);
    repeat (6) @(negedge clk);
    chk(status == done_status, "R10 status held", status, done_status);
    chk(done_cnt == d0 + 1, "R9 no second done", done_cnt - d0, 1);
  endtask

  task automatic check_reads(input int nblk);
    chk(log_kind[0] == 2'd0 && log_dev[0] == 7'h50 && log_addr[0] == 20'h7E,
        "R2 first request", int'(log_addr[0]), 'h7E);
    for (int i = 0; i < nblk * 128; i++)
      if (log_kind[i+1] != 2'd0 || log_addr[i+1] != 20'(i) || log_dev[i+1] != 7'h50) begin
        chk(0, i < 128 ? "R3 block0 offset" : "R4 block1 offset", int'(log_addr[i+1]), i);
        break;
      end
    checks++;
  endtask

  task automatic rd_check(input int a, input string req);
    @(negedge clk); rd_addr = 8'(a);
    @(negedge clk);
    chk(rd_data == sink_mem[a], req, rd_data, sink_mem[a]);
  endtask

  task automatic t_reset;
    chk(busy == 0 && done == 0 && aux_req_valid == 0, "R1 reset outputs", {busy, done, aux_req_valid}, 0);
    chk(status == 2'd0, "R1 reset status", status, 0);
  endtask

  task automatic t_single_block;
    build(8'h00, 0, 0, 1); test_reg = 8'h00; fail_at = -1; lat = 0;
    run(-1);
    chk(ntx == 130, "R4 single block count", ntx, 130);
    check_reads(1);
    chk(log_kind[129] == 2'd1 && log_addr[129] == 20'h00218, "R6 test request read", int'(log_addr[129]), 'h218);
    chk(done_status == 2'd1, "R6 status ok", done_status, 1);
    rd_check(0, "R3 buffer 0");
    rd_check(77, "R3 buffer 77");
    rd_check(127, "R3 buffer 127");
  endtask

  task automatic t_two_block_test;
    build(8'h01, 0, 0, 2); test_reg = 8'h04; fail_at = -1; lat = 3;
    run(-1);
    chk(ntx == 260, "R7 two block count", ntx, 260);
    check_reads(2);
    chk(log_kind[258] == 2'd2 && log_addr[258] == 20'h00261 && log_data[258] == sink_mem[255],
        "R7 checksum write", log_data[258], sink_mem[255]);
    chk(log_kind[259] == 2'd2 && log_addr[259] == 20'h00260 && log_data[259] == 8'h04,
        "R7 response write", log_data[259], 4);
    chk(done_status == 2'd1, "R7 status ok", done_status, 1);
    rd_check(128, "R4 buffer 128");
    rd_check(255, "R4 buffer 255");
  endtask

  task automatic t_single_test;
    build(8'h00, 0, 0, 3); test_reg = 8'hFF; fail_at = -1; lat = 1;
    run(-1);
    chk(ntx == 132, "R7 single block test count", ntx, 132);
    chk(log_data[130] == sink_mem[127], "R7 block0 checksum byte", log_data[130], sink_mem[127]);
  endtask

  task automatic t_csum_bad;
    build(8'h02, 1, 0, 4); test_reg = 8'h04; fail_at = -1; lat = 0;
    run(-1);
    chk(done_status == 2'd2, "R5 block0 bad status", done_status, 2);
    chk(ntx == 129, "R5 block0 bad count", ntx, 129);
    build(8'h01, 0, 1, 5); lat = 2;
    run(-1);
    chk(done_status == 2'd2, "R5 block1 bad status", done_status, 2);
    chk(ntx == 257, "R5 block1 bad count", ntx, 257);
  endtask

  task automatic t_ioerr;
    build(8'h01, 0, 0, 6); test_reg = 8'h04; lat = 0;
    fail_at = 5;
    run(-1);
    chk(done_status == 2'd3, "R8 read fail status", done_status, 3);
    chk(ntx == 6, "R8 read fail count", ntx, 6);
    fail_at = 258;
    run(-1);
    chk(done_status == 2'd3, "R8 write fail status", done_status, 3);
    chk(ntx == 259, "R8 write fail count", ntx, 259);
    fail_at = -1;
  endtask

  task automatic t_start_busy;
    build(8'h00, 0, 0, 7); test_reg = 8'h00; fail_at = -1; lat = 1;
    run(40);
    chk(ntx == 130, "R9 count with extra start", ntx, 130);
    chk(done_status == 2'd1, "R9 status", done_status, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_block();
    t_two_block_test();
    t_single_test();
    t_csum_bad();
    t_ioerr();
    t_start_busy();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule